// File: doc/BRIEF.md
# Clock and Power Mode Controller

This block sequences a chip through four operating modes (normal, slow, idle and sleep). It drives the enables and selects that the external clock and power cells consume: a CPU clock gate, one gate per peripheral clock, a PLL-or-reference select for the CPU clock, a core power-domain enable and a core reset. It runs entirely on the always-on reference clock and reset, so its registers and wake logic survive while the core domain is unpowered.

Software moves between modes by writing a mode code through a small register port. It also programs which peripheral clocks run and how long the core is held after power returns. Idle mode is left when an interrupt request is raised. Sleep mode is left on a rising edge of any of the external wake lines or of the real-time-clock alarm. Every exit lands in normal mode on the PLL clock. The clock select only ever moves while the CPU clock gate is closed on both sides of the change.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the block reports normal mode (code 0), selects the PLL (pll_sel=1), enables the CPU clock, enables every peripheral clock, drives core_pwr_en=1 and core_rst_n=1, and the status register (address 3) reads 0.
- R2: Address 1 holds one enable bit per peripheral (bit i for peripheral i, reset value all ones). In normal, slow and idle mode, periph_clk_en equals this mask one cycle after the write.
- R3: Mode codes written to address 0 bits [1:0] are 0 normal, 1 slow, 2 idle and 3 sleep. Writing 1 in normal mode moves the CPU clock onto the external reference (pll_sel=0). Writing 0 in slow mode moves it back to the PLL. Both reach the new mode with the CPU clock enabled again.
- R4: pll_sel never changes unless cpu_clk_en is low both in the cycle before the change and in the cycle of the change.
- R5: Writing 2 from normal or slow mode stops only the CPU clock: peripheral clocks follow the mask. A high irq_req then returns the block to normal mode on the PLL with the CPU clock running.
- R6: Writing 3 closes the CPU and peripheral clocks for ENTRY_CYC cycles with core power still on. After that, core_pwr_en and core_rst_n go low.
- R7: In sleep, a rising edge on any ext_wake line or on rtc_alarm, passed through an SYNC_STAGES-flop synchroniser, starts the wake-up. A line that is already high when sleep begins does not wake the block.
- R8: On wake, core_pwr_en rises first. core_rst_n and cpu_clk_en then stay low for max(S,1) cycles, where S is the stabilisation count at address 2. After that the block returns to normal mode on the PLL.
- R9: A wake edge that reaches the sequencer while the ENTRY_CYC countdown is still running cancels the entry. The block returns to normal mode without core_pwr_en ever going low.
- R10: Status (address 3) holds the current mode code in bits [1:0] and the wake edges that ended the last sleep or entry in bits [18:2]: bit 2+i for ext_wake[i] and bit 18 for rtc_alarm. Reading address 3 clears bits [18:2].
- R11: In normal mode, irq_req and wake edges have no effect on the mode, the clocks or the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Always-on reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status wake field at address 3) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr |
| irq_req | input | 1 | Interrupt request to the CPU, ends idle mode |
| ext_wake | input | N_EXT_WAKE | External wake lines, asynchronous |
| rtc_alarm | input | 1 | Real-time-clock alarm wake, asynchronous |
| pll_sel | output | 1 | CPU clock source: 1 PLL, 0 external reference |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| periph_clk_en | output | N_PERIPH | Per-peripheral clock gate enables |
| core_pwr_en | output | 1 | Core power-domain switch enable |
| core_rst_n | output | 1 | Core reset, active low |

## Verification
The two functions that can meet in one cycle are the sleep-entry countdown reaching its last cycle and a synchronised wake edge arriving. The bench raises a wake line at a swept number of cycles after the sleep write, so the edge lands before, on and after the final entry cycle. For each offset it predicts, from ENTRY_CYC and the synchroniser depth, whether the entry is cancelled with power kept on or completed and then woken. It judges the result by watching core_pwr_en for any low cycle and by reading the wake source back from the status register.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

   typedef enum logic [1:0] {
      MODE_NORMAL = 2'd0,
      MODE_SLOW   = 2'd1,
      MODE_IDLE   = 2'd2,
      MODE_SLEEP  = 2'd3
   } pmc_mode_e;

   typedef enum logic [2:0] {
      ST_RUN,
      ST_SLOW,
      ST_SW_A,
      ST_SW_B,
      ST_IDLE,
      ST_ENTER,
      ST_OFF,
      ST_STAB
   } pmc_state_e;

   localparam logic [1:0] ADDR_MODE   = 2'd0;
   localparam logic [1:0] ADDR_PERIPH = 2'd1;
   localparam logic [1:0] ADDR_STAB   = 2'd2;
   localparam logic [1:0] ADDR_STATUS = 2'd3;

endpackage

// File: rtl/pmc_wake_sync.sv
module pmc_wake_sync #(
   parameter int WIDTH       = 17,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] rise
);

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("pmc_wake_sync: SYNC_STAGES must be at least 2");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_line
      logic [SYNC_STAGES-1:0] chain;
      logic                   last_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain  <= '0;
            last_q <= 1'b0;
         end else begin
            chain  <= {chain[SYNC_STAGES-2:0], async_in[i]};
            last_q <= chain[SYNC_STAGES-1];
         end
      end

      assign rise[i] = chain[SYNC_STAGES-1] & ~last_q;
   end

endmodule

// File: rtl/pmc_clk_gates.sv
module pmc_clk_gates #(
   parameter int N_PERIPH = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_PERIPH-1:0] en_mask,
   input  logic                run,
   output logic [N_PERIPH-1:0] gate_en
);

   for (genvar i = 0; i < N_PERIPH; i++) begin : g_gate
      assign gate_en[i] = run & en_mask[i];
   end

   // R2: a peripheral whose mask bit is clear is never clocked
   a_r2_masked_off: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_en & ~en_mask) == '0);

endmodule

// File: rtl/pmc_seq.sv
module pmc_seq
   import pmc_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter int ENTRY_CYC = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_wr,
   input  logic [1:0]       mode_code,
   input  logic [CNT_W-1:0] stab_val,
   input  logic             irq_req,
   input  logic             wake_any,
   output pmc_mode_e        cur_mode,
   output logic             wake_take,
   output logic             pll_sel,
   output logic             cpu_clk_en,
   output logic             periph_run,
   output logic             core_pwr_en,
   output logic             core_rst_n
);

   localparam logic [CNT_W-1:0] ENTRY_LOAD = CNT_W'(ENTRY_CYC);

   pmc_state_e       state;
   pmc_mode_e        tgt;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_RUN;
         tgt     <= MODE_NORMAL;
         cnt     <= '0;
         pll_sel <= 1'b1;
      end else begin
         unique case (state)
            ST_RUN, ST_SLOW: begin
               if (mode_wr) begin
                  unique case (pmc_mode_e'(mode_code))
                     MODE_NORMAL: if (state == ST_SLOW) begin
                        tgt   <= MODE_NORMAL;
                        state <= ST_SW_A;
                     end
                     MODE_SLOW: if (state == ST_RUN) begin
                        tgt   <= MODE_SLOW;
                        state <= ST_SW_A;
                     end
                     MODE_IDLE:  state <= ST_IDLE;
                     MODE_SLEEP: begin
                        state <= ST_ENTER;
                        cnt   <= ENTRY_LOAD;
                     end
                  endcase
               end
            end
            ST_SW_A: begin
               pll_sel <= (tgt == MODE_NORMAL);
               state   <= ST_SW_B;
            end
            ST_SW_B: state <= (tgt == MODE_SLOW) ? ST_SLOW : ST_RUN;
            ST_IDLE: if (irq_req) begin
               tgt   <= MODE_NORMAL;
               state <= ST_SW_A;
            end
            ST_ENTER: begin
               if (wake_any) begin
                  tgt   <= MODE_NORMAL;
                  state <= ST_SW_A;
               end else if (cnt <= 1) begin
                  state <= ST_OFF;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_OFF: if (wake_any) begin
               state <= ST_STAB;
               cnt   <= (stab_val == '0) ? CNT_W'(1) : stab_val;
            end
            ST_STAB: begin
               if (cnt <= 1) begin
                  tgt   <= MODE_NORMAL;
                  state <= ST_SW_A;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: state <= ST_RUN;
         endcase
      end
   end

   always_comb begin
      cpu_clk_en  = (state == ST_RUN) || (state == ST_SLOW);
      periph_run  = (state == ST_RUN) || (state == ST_SLOW) || (state == ST_IDLE) ||
                    (state == ST_SW_A) || (state == ST_SW_B);
      core_pwr_en = (state != ST_OFF);
      core_rst_n  = (state != ST_OFF) && (state != ST_STAB);
      wake_take   = wake_any && ((state == ST_ENTER) || (state == ST_OFF));
      unique case (state)
         ST_RUN:              cur_mode = MODE_NORMAL;
         ST_SLOW:             cur_mode = MODE_SLOW;
         ST_IDLE:             cur_mode = MODE_IDLE;
         ST_SW_A, ST_SW_B:    cur_mode = tgt;
         default:             cur_mode = MODE_SLEEP;
      endcase
   end

   // R4: the select only moves with the CPU gate closed on both sides
   a_r4_sel_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
      (pll_sel != $past(pll_sel)) |-> (!cpu_clk_en && !$past(cpu_clk_en)));

   // R6: with core power off nothing is clocked and reset is held
   a_r6_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !core_pwr_en |-> (!cpu_clk_en && !periph_run && !core_rst_n));

   // R8: power returns before reset release and CPU clock
   a_r8_power_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(core_pwr_en) |-> (!core_rst_n && !cpu_clk_en));

   // R8: stabilisation countdown advances by one per cycle
   a_r8_stab_count: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_STAB && $past(state) == ST_STAB) |-> (cnt == $past(cnt) - 1'b1));

   // R5: idle keeps the CPU gated and peripherals running
   a_r5_idle_gating: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode == MODE_IDLE && state == ST_IDLE) |-> (!cpu_clk_en && periph_run));

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
   import pmc_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int N_PERIPH    = 8,
   parameter int N_EXT_WAKE  = 16,
   parameter int CNT_W       = 16,
   parameter int ENTRY_CYC   = 4,
   parameter int STAB_RST    = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_wr,
   input  logic                  reg_rd,
   input  logic [1:0]            reg_addr,
   input  logic [DATA_W-1:0]     reg_wdata,
   output logic [DATA_W-1:0]     reg_rdata,
   input  logic                  irq_req,
   input  logic [N_EXT_WAKE-1:0] ext_wake,
   input  logic                  rtc_alarm,
   output logic                  pll_sel,
   output logic                  cpu_clk_en,
   output logic [N_PERIPH-1:0]   periph_clk_en,
   output logic                  core_pwr_en,
   output logic                  core_rst_n
);

   localparam int N_SRC = N_EXT_WAKE + 1;

   if (N_SRC + 2 > DATA_W) begin : g_bad_status
      $error("pwr_mode_ctrl: status field does not fit DATA_W");
   end
   if (N_PERIPH < 1 || N_PERIPH > DATA_W) begin : g_bad_periph
      $error("pwr_mode_ctrl: N_PERIPH out of range");
   end
   if (CNT_W > DATA_W || ENTRY_CYC < 1 || ENTRY_CYC >= (1 << CNT_W)) begin : g_bad_cnt
      $error("pwr_mode_ctrl: counter parameters out of range");
   end

   logic [N_PERIPH-1:0] periph_mask;
   logic [CNT_W-1:0]    stab_q;
   logic [N_SRC-1:0]    wake_field;
   logic [N_SRC-1:0]    wake_rise;
   logic                wake_take;
   logic                periph_run;
   pmc_mode_e           cur_mode;
   logic                unused_wdata;

   assign unused_wdata = ^reg_wdata;

   pmc_wake_sync #(.WIDTH(N_SRC), .SYNC_STAGES(SYNC_STAGES)) i_wake_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in ({rtc_alarm, ext_wake}),
      .rise     (wake_rise)
   );

   pmc_seq #(.CNT_W(CNT_W), .ENTRY_CYC(ENTRY_CYC)) i_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_wr     (reg_wr && reg_addr == ADDR_MODE),
      .mode_code   (reg_wdata[1:0]),
      .stab_val    (stab_q),
      .irq_req     (irq_req),
      .wake_any    (|wake_rise),
      .cur_mode    (cur_mode),
      .wake_take   (wake_take),
      .pll_sel     (pll_sel),
      .cpu_clk_en  (cpu_clk_en),
      .periph_run  (periph_run),
      .core_pwr_en (core_pwr_en),
      .core_rst_n  (core_rst_n)
   );

   pmc_clk_gates #(.N_PERIPH(N_PERIPH)) i_gates (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_mask (periph_mask),
      .run     (periph_run),
      .gate_en (periph_clk_en)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         periph_mask <= '1;
         stab_q      <= CNT_W'(STAB_RST);
         wake_field  <= '0;
      end else begin
         if (reg_wr && reg_addr == ADDR_PERIPH) periph_mask <= reg_wdata[N_PERIPH-1:0];
         if (reg_wr && reg_addr == ADDR_STAB)   stab_q      <= reg_wdata[CNT_W-1:0];
         if (wake_take)
            wake_field <= wake_rise;
         else if (reg_rd && reg_addr == ADDR_STATUS)
            wake_field <= '0;
      end
   end

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         ADDR_MODE:   reg_rdata[1:0] = cur_mode;
         ADDR_PERIPH: reg_rdata[N_PERIPH-1:0] = periph_mask;
         ADDR_STAB:   reg_rdata[CNT_W-1:0] = stab_q;
         default: begin
            reg_rdata[1:0]       = cur_mode;
            reg_rdata[N_SRC+1:2] = wake_field;
         end
      endcase
   end

   // R10: the wake field only changes on a wake latch or a status read
   a_r10_field_stable: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!wake_take) && !($past(reg_rd) && $past(reg_addr) == ADDR_STATUS))
      |-> $stable(wake_field));

endmodule

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;

   localparam int DW    = 32;
   localparam int NP    = 8;
   localparam int NW    = 16;
   localparam int ENTRY = 4;
   localparam int SYNC  = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic          reg_rd = 1'b0;
   logic [1:0]    reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          irq_req = 1'b0;
   logic [NW-1:0] ext_wake = '0;
   logic          rtc_alarm = 1'b0;
   logic          pll_sel, cpu_clk_en, core_pwr_en, core_rst_n;
   logic [NP-1:0] periph_clk_en;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   logic [NP-1:0] mask = '1;

   always #10 clk = ~clk;

   pwr_mode_ctrl i_pwr_mode_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_req(irq_req), .ext_wake(ext_wake), .rtc_alarm(rtc_alarm),
      .pll_sel(pll_sel), .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
      .core_pwr_en(core_pwr_en), .core_rst_n(core_rst_n)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] status_of(input logic [1:0] mode, input logic [17:0] field);
      return {13'd0, field[16:0], mode};
   endfunction

   function automatic bit expect_abort(input int j);
      return (j + 1 + SYNC) <= ENTRY;
   endfunction

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic set_src(input int s, input logic v);
      if (s == NW) rtc_alarm = v; else ext_wake[s] = v;
   endtask

   // R4: watch every select change at the ports
   logic prev_sel = 1'b1, prev_cpu = 1'b1;
   always @(negedge clk) begin
      if (rst_n) begin
         if (pll_sel !== prev_sel)
            chk(!cpu_clk_en && !prev_cpu, "R4 gate low around select change",
                {30'd0, prev_cpu, cpu_clk_en}, 32'd0);
         prev_sel <= pll_sel;
         prev_cpu <= cpu_clk_en;
      end
   end

   bit saw_off = 1'b0;
   always @(negedge clk) if (rst_n && !core_pwr_en) saw_off <= 1'b1;

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      int n, m;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(pll_sel && cpu_clk_en, "R1 clock after reset", {30'd0, pll_sel, cpu_clk_en}, 32'd3);
      chk(periph_clk_en == '1, "R1 periph after reset", periph_clk_en, 32'hff);
      chk(core_pwr_en && core_rst_n, "R1 power after reset", {30'd0, core_pwr_en, core_rst_n}, 32'd3);
      rd(2'd3, d);
      chk(d == 32'd0, "R1 status after reset", d, 32'd0);

      // R11 irq and wake edges in normal mode have no effect
      irq_req = 1'b1; ext_wake[3] = 1'b1; rtc_alarm = 1'b1;
      repeat (6) @(negedge clk);
      chk(cpu_clk_en && core_pwr_en && pll_sel, "R11 normal undisturbed",
          {29'd0, cpu_clk_en, core_pwr_en, pll_sel}, 32'd7);
      rd(2'd3, d);
      chk(d == status_of(2'd0, '0), "R11 status unchanged", d, status_of(2'd0, '0));
      irq_req = 1'b0; ext_wake = '0; rtc_alarm = 1'b0;
      repeat (4) @(negedge clk);

      // R2 random peripheral masks
      for (int i = 0; i < 6; i++) begin
         mask = NP'($urandom);
         wr(2'd1, {24'd0, mask});
         chk(periph_clk_en == mask, "R2 periph mask", periph_clk_en, mask);
      end

      // R3 slow and back
      wr(2'd0, 32'd1);
      repeat (3) @(negedge clk);
      rd(2'd0, d);
      chk(!pll_sel && cpu_clk_en && d == 32'd1, "R3 slow entered", {pll_sel, cpu_clk_en, d[1:0]}, 32'h5);
      chk(periph_clk_en == mask, "R3 periph in slow", periph_clk_en, mask);
      wr(2'd0, 32'd0);
      repeat (3) @(negedge clk);
      rd(2'd0, d);
      chk(pll_sel && cpu_clk_en && d == 32'd0, "R3 normal again", {pll_sel, cpu_clk_en, d[1:0]}, 32'hc);

      // R5 idle from normal or slow
      for (int i = 0; i < 4; i++) begin
         if (i % 2 == 1) begin
            wr(2'd0, 32'd1);
            repeat (3) @(negedge clk);
         end
         wr(2'd0, 32'd2);
         repeat (1 + $urandom_range(0, 5)) @(negedge clk);
         rd(2'd0, d);
         chk(!cpu_clk_en && d == 32'd2, "R5 idle gating", {cpu_clk_en, d[1:0]}, 32'd2);
         chk(periph_clk_en == mask, "R5 idle periph", periph_clk_en, mask);
         irq_req = 1'b1;
         repeat (4) @(negedge clk);
         irq_req = 1'b0;
         rd(2'd0, d);
         chk(cpu_clk_en && pll_sel && d == 32'd0, "R5 idle exit", {cpu_clk_en, pll_sel, d[1:0]}, 32'hc);
      end

      // R6 R7 R8 R10 sleep with random source and stabilisation count
      for (int i = 0; i < 6; i++) begin
         int src, stab, exp_stab;
         src  = (i == 0) ? NW : $urandom_range(0, NW);
         stab = (i == 1) ? 0 : $urandom_range(1, 20);
         exp_stab = (stab == 0) ? 1 : stab;
         if (i % 3 == 2) begin
            wr(2'd0, 32'd1);
            repeat (3) @(negedge clk);
         end
         wr(2'd2, stab);
         wr(2'd0, 32'd3);
         n = 0;
         while (core_pwr_en && n < 50) begin
            if (cpu_clk_en || periph_clk_en != '0) n = 100;
            n++;
            @(negedge clk);
         end
         chk(n == ENTRY, "R6 entry cycles clocks off", n, ENTRY);
         chk(!core_pwr_en && !core_rst_n, "R6 power off", {core_pwr_en, core_rst_n}, 32'd0);
         repeat ($urandom_range(0, 10)) @(negedge clk);
         chk(!core_pwr_en, "R6 stays asleep", core_pwr_en, 32'd0);
         set_src(src, 1'b1);
         n = 0;
         while (!core_pwr_en && n < 20) begin n++; @(negedge clk); end
         m = 0;
         while (!core_rst_n && m < 100) begin
            if (cpu_clk_en) m = 200;
            m++;
            @(negedge clk);
         end
         chk(m == exp_stab, "R8 stabilisation cycles", m, exp_stab);
         repeat (3) @(negedge clk);
         chk(cpu_clk_en && pll_sel && periph_clk_en == mask, "R8 back to normal on pll",
             {cpu_clk_en, pll_sel, periph_clk_en}, {2'b11, mask});
         set_src(src, 1'b0);
         rd(2'd3, d);
         chk(d == status_of(2'd0, 18'(1) << src), "R10 wake source", d, status_of(2'd0, 18'(1) << src));
         rd(2'd3, d);
         chk(d == status_of(2'd0, '0), "R10 cleared on read", d, status_of(2'd0, '0));
      end

      // R7 a line already high before sleep does not wake
      wr(2'd2, 32'd2);
      ext_wake[5] = 1'b1;
      repeat (5) @(negedge clk);
      wr(2'd0, 32'd3);
      repeat (20) @(negedge clk);
      chk(!core_pwr_en, "R7 held level ignored", core_pwr_en, 32'd0);
      ext_wake[9] = 1'b1;
      repeat (12) @(negedge clk);
      chk(core_pwr_en && cpu_clk_en, "R7 edge wakes", {core_pwr_en, cpu_clk_en}, 32'd3);
      rd(2'd3, d);
      chk(d == status_of(2'd0, 18'(1) << 9), "R7 only new edge recorded", d, status_of(2'd0, 18'(1) << 9));
      ext_wake = '0;
      repeat (4) @(negedge clk);

      // R9 wake edge swept across the end of the entry countdown
      for (int j = 0; j < 4; j++) begin
         int src;
         src = $urandom_range(0, NW);
         wr(2'd2, 32'd1);
         wr(2'd0, 32'd3);
         saw_off = 1'b0;
         repeat (j) @(negedge clk);
         set_src(src, 1'b1);
         repeat (15) @(negedge clk);
         chk(saw_off == !expect_abort(j), "R9 abort versus completed entry", saw_off, !expect_abort(j));
         chk(cpu_clk_en && pll_sel && core_pwr_en, "R9 ends in normal",
             {cpu_clk_en, pll_sel, core_pwr_en}, 32'd7);
         set_src(src, 1'b0);
         rd(2'd3, d);
         chk(d == status_of(2'd0, 18'(1) << src), "R9 wake recorded", d, status_of(2'd0, 18'(1) << src));
         repeat (4) @(negedge clk);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule